// File: doc/BRIEF.md
# Sponge Absorb Padding Controller

This block sits between a 64-bit byte-strobed message stream and a Keccak-f permutation engine. It controls the absorb side of a sponge hash. The permutation engine is fed one 64-bit lane per transfer. A transfer happens when `perm_valid_o` and `perm_ready_i` are both high. A word counter tracks the position inside the current rate block. The block stops sending when the counter reaches the rate limit. It resumes from lane zero once the permutation pulses `perm_done_i`.

A run begins with `start_i` while idle. The customizable-SHAKE mode first streams one full block of prefix words. It reads these from `pfx_word_i` at the index shown on `word_idx_o`. After the prefix, message words pass through unchanged. The end of the message is marked in one of two ways:

- a word whose strobe is not all ones, or
- a pulse on `process_i`, which is remembered if the block is busy.

The controller then emits a padding word, fills the rest of the block with zeros, and sets the top bit of the block's last lane. It then waits for the final permutation and returns to idle. An escalation input forces a terminal error state that only reset clears.

Top module: `sponge_pad_ctrl`

## Requirements
- R1: After reset the block is idle. `perm_valid_o`, `msg_ready_o` and `err_o` are low, and they stay low while idle even with `msg_valid_i` high.
- R2: With `mode_i`=2 (cSHAKE), `start_i` in idle first sends exactly one block of prefix words. Each word is `pfx_word_i` sampled while `word_idx_o` equals its lane index. The block then waits for `perm_done_i` before message words are taken.
- R3: With `mode_i`=0 (SHA3) or 1 (SHAKE), `start_i` goes straight to message transfer. Full-strobe words are forwarded unchanged, and `msg_ready_o` is high only when `perm_ready_i` is high.
- R4: The block limit in lanes is 21, 18, 17, 13 and 9 for `strength_i` codes 0 to 4 (128, 224, 256, 384, 512). Codes 5 to 7 use 9.
- R5: Once a block holds its limit of lanes, `perm_valid_o` stays low until `perm_done_i`. Transfer then resumes at lane 0.
- R6: A message word with strobe not all ones is partial. Its strobe is contiguous from bit 0 and marks n = 0..7 valid bytes. It is consumed as the padding word: bytes 0..n-1 come from the message, byte n holds the suffix, and higher bytes are zero.
- R7: The suffix byte is 0x06 for mode 0, 0x1F for mode 1 and 0x04 for mode 2. When the end is marked by `process_i` with no partial word, the padding word is the suffix at byte 0.
- R8: After the padding word, zero lanes follow until the block is full. Bit 63 of the block's last lane is set, and this includes the case where the padding word is itself the last lane.
- R9: A `process_i` pulse is latched, including one given while a full block waits for `perm_done_i`. After the final block, `perm_done_i` returns the block to idle.
- R10: `esc_i` sets `err_o` on the next cycle, in any state. The error persists until reset, with `perm_valid_o` and `msg_ready_o` held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 0 SHA3, 1 SHAKE, 2 cSHAKE (3 acts as SHA3) |
| strength_i | input | 3 | Security strength code, selects block limit |
| start_i | input | 1 | Begin a run (used in idle) |
| process_i | input | 1 | End-of-message request pulse |
| esc_i | input | 1 | Escalation, forces terminal error |
| msg_valid_i | input | 1 | Message word valid |
| msg_data_i | input | 64 | Message word, byte 0 in bits 7:0 |
| msg_strb_i | input | 8 | Byte strobes of the message word |
| msg_ready_o | output | 1 | Message word accepted |
| pfx_word_i | input | 64 | Prefix word for lane `word_idx_o` |
| word_idx_o | output | 5 | Current lane index in the block |
| perm_valid_o | output | 1 | Lane valid toward the permutation |
| perm_data_o | output | 64 | Lane data toward the permutation |
| perm_ready_i | input | 1 | Permutation accepts a lane |
| perm_done_i | input | 1 | Permutation of the current block finished |
| err_o | output | 1 | Terminal error state |

## Verification
Two situations are hard to reach from the ports. The first is an end-of-message request that arrives while a full block is still waiting on the permutation. The bench reaches it by sending a message of exactly one block and pulsing `process_i` in the cycle after the ninth lane is accepted, so the request must be remembered. The second is the padding word landing on the last lane, where the suffix and bit 63 share one word. The bench reaches it by sending one lane short of the limit followed by a one-byte partial word. A stand-in permutation model pulses `perm_done_i` three cycles after each full block and flags any lane offered in that gap.

// File: rtl/sponge_pad_ctrl.sv
module sponge_pad_ctrl #(
  parameter int DW = 64,
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic [2:0]    strength_i,
  input  logic          start_i,
  input  logic          process_i,
  input  logic          esc_i,
  input  logic          msg_valid_i,
  input  logic [DW-1:0] msg_data_i,
  input  logic [DW/8-1:0] msg_strb_i,
  output logic          msg_ready_o,
  input  logic [DW-1:0] pfx_word_i,
  output logic [CW-1:0] word_idx_o,
  output logic          perm_valid_o,
  output logic [DW-1:0] perm_data_o,
  input  logic          perm_ready_i,
  input  logic          perm_done_i,
  output logic          err_o
);
  localparam int NB = DW / 8;

  typedef enum logic [3:0] {
    S_IDLE, S_PFX, S_PFXW, S_MSG, S_MSGW, S_PAD, S_PEND, S_ZFILL, S_FLUSH, S_ERR
  } st_e;

  st_e st, nx;
  logic [CW-1:0] cnt, lim;
  logic proc_l;

  always_comb begin
    case (strength_i)
      3'd0:    lim = CW'(21);
      3'd1:    lim = CW'(18);
      3'd2:    lim = CW'(17);
      3'd3:    lim = CW'(13);
      default: lim = CW'(9);
    endcase
  end

  wire full    = (cnt == lim);
  wire last_w  = (cnt == lim - CW'(1));
  wire ack     = perm_valid_o & perm_ready_i;
  wire partial = msg_valid_i & ~(&msg_strb_i);
  wire pass    = ~full & ~partial & ~proc_l & ~process_i;

  logic [7:0] sfx;
  always_comb begin
    case (mode_i)
      2'd1:    sfx = 8'h1F;
      2'd2:    sfx = 8'h04;
      default: sfx = 8'h06;
    endcase
  end

  logic [3:0] nbytes;
  always_comb begin
    nbytes = '0;
    for (int b = 0; b < NB; b++) nbytes = nbytes + 4'(msg_strb_i[b]);
  end

  logic [DW-1:0] padw;
  always_comb begin
    for (int b = 0; b < NB; b++) begin
      if (partial && 4'(b) < nbytes)       padw[b*8 +: 8] = msg_data_i[b*8 +: 8];
      else if (4'(b) == (partial ? nbytes : 4'd0)) padw[b*8 +: 8] = sfx;
      else                                 padw[b*8 +: 8] = 8'h00;
    end
    if (last_w) padw[DW-1] = 1'b1;
  end

  always_comb begin
    nx = st;
    case (st)
      S_IDLE:  if (start_i) nx = (mode_i == 2'd2) ? S_PFX : S_MSG;
      S_PFX:   if (full) nx = S_PFXW;
      S_PFXW:  if (perm_done_i) nx = S_MSG;
      S_MSG: begin
        if (full)                      nx = S_MSGW;
        else if (partial)              nx = S_PAD;
        else if (proc_l || process_i)  nx = S_PAD;
      end
      S_MSGW:  if (perm_done_i) nx = S_MSG;
      S_PAD:   if (ack) nx = last_w ? S_PEND : S_ZFILL;
      S_PEND:  nx = S_FLUSH;
      S_ZFILL: if (full) nx = S_FLUSH;
      S_FLUSH: if (perm_done_i) nx = S_IDLE;
      S_ERR:   nx = S_ERR;
      default: nx = S_ERR;
    endcase
    if (esc_i) nx = S_ERR;
  end

  always_comb begin
    perm_valid_o = 1'b0;
    perm_data_o  = msg_data_i;
    msg_ready_o  = 1'b0;
    case (st)
      S_PFX: begin
        perm_valid_o = ~full;
        perm_data_o  = pfx_word_i;
      end
      S_MSG: begin
        perm_valid_o = pass & msg_valid_i;
        msg_ready_o  = pass & perm_ready_i;
      end
      S_PAD: begin
        perm_valid_o = 1'b1;
        perm_data_o  = padw;
        msg_ready_o  = partial & perm_ready_i;
      end
      S_ZFILL: begin
        perm_valid_o = ~full;
        perm_data_o  = {last_w, {(DW-1){1'b0}}};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= S_IDLE;
      cnt    <= '0;
      proc_l <= 1'b0;
    end else begin
      st <= nx;
      if ((st == S_IDLE && start_i) || perm_done_i) cnt <= '0;
      else if (ack)                                 cnt <= cnt + CW'(1);
      if (st == S_IDLE)   proc_l <= 1'b0;
      else if (process_i) proc_l <= 1'b1;
    end
  end

  assign word_idx_o = cnt;
  assign err_o      = (st == S_ERR);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_IDLE) |-> (!perm_valid_o && !msg_ready_o));
  a_r3_ready_needs_sink: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_ready_o |-> perm_ready_i);
  a_r5_no_lane_past_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perm_valid_o |-> (cnt < lim));
  a_r5_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= lim);
  a_r10_esc_enters: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_i |=> err_o);
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  a_r10_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!perm_valid_o && !msg_ready_o));
endmodule

// File: tb/sponge_pad_ctrl_tb.sv
`timescale 1ns/1ps
module sponge_pad_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic [2:0] strength = 0;
  logic start = 0, process = 0, esc = 0;
  logic msg_valid = 0;
  logic [63:0] msg_data = 0;
  logic [7:0] msg_strb = 0;
  logic msg_ready;
  logic [63:0] pfx_word;
  logic [4:0] word_idx;
  logic perm_valid, perm_ready = 1, perm_done = 0, err;
  logic [63:0] perm_data;

  int n_tests = 0, n_fail = 0;
  bit  ended = 0;
  logic [63:0] got [0:63];
  logic [63:0] exp [0:63];
  int ngot, nexp;

  always #2 clk = ~clk;
  assign pfx_word = 64'hF0F0_0000_0000_0000 | 64'(word_idx);

  sponge_pad_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .strength_i(strength),
    .start_i(start), .process_i(process), .esc_i(esc),
    .msg_valid_i(msg_valid), .msg_data_i(msg_data), .msg_strb_i(msg_strb),
    .msg_ready_o(msg_ready), .pfx_word_i(pfx_word), .word_idx_o(word_idx),
    .perm_valid_o(perm_valid), .perm_data_o(perm_data),
    .perm_ready_i(perm_ready), .perm_done_i(perm_done), .err_o(err));

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] ex);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, ex);
    end
  endtask

  function automatic int lim_of(int s);
    case (s) 0: return 21; 1: return 18; 2: return 17; 3: return 13; default: return 9; endcase
  endfunction
  function automatic logic [7:0] sfx_of(int m);
    case (m) 1: return 8'h1F; 2: return 8'h04; default: return 8'h06; endcase
  endfunction
  function automatic logic [63:0] wd(int i);
    return {32'hC0DE_0000, 32'(i * 7 + 1)};
  endfunction
  localparam logic [63:0] PD = 64'h1122_3344_5566_7788;

  task automatic absorb(string tag, int md, int st, int nfull, bit part, logic [7:0] pstrb, bit stall);
    int lim = lim_of(st);
    int mi = 0, blk = 0, wt = 0, ppos = 0, n = 0;
    bit proc_sent = 0, fin = 0, gap_bad = 0;
    logic [63:0] pw = 0;
    nexp = 0; ngot = 0;
    if (md == 2) for (int i = 0; i < lim; i++) exp[nexp++] = 64'hF0F0_0000_0000_0000 | 64'(i);
    for (int i = 0; i < nfull; i++) exp[nexp++] = wd(i);
    if (part) begin
      for (int b = 0; b < 8; b++) n += int'(pstrb[b]);
      for (int b = 0; b < n; b++) pw[b*8 +: 8] = PD[b*8 +: 8];
    end
    pw[n*8 +: 8] = sfx_of(md);
    ppos = nexp;
    exp[nexp++] = pw;
    while (nexp % lim != 0) exp[nexp++] = 64'h0;
    exp[nexp-1][63] = 1'b1;

    mode = 2'(md); strength = 3'(st);
    start = 1; tick; start = 0;
    for (int cyc = 0; cyc < 800 && !fin; cyc++) begin
      if (mi < nfull) begin msg_valid = 1; msg_data = wd(mi); msg_strb = 8'hFF; end
      else if (part && mi == nfull) begin msg_valid = 1; msg_data = PD; msg_strb = pstrb; end
      else begin msg_valid = 0; msg_data = 0; msg_strb = 0; end
      process   = !part && mi == nfull && !proc_sent;
      perm_ready = !(stall && (cyc % 3 == 1));
      perm_done = (blk == lim && wt == 3);
      #1;
      if (msg_ready && !perm_ready) gap_bad = 1;
      if (blk == lim && perm_valid) gap_bad = 1;
      if (msg_valid && msg_ready) mi++;
      if (perm_valid && perm_ready && ngot < 64) begin got[ngot++] = perm_data; blk++; end
      if (process) proc_sent = 1;
      if (perm_done) begin blk = 0; wt = 0; if (ngot >= nexp) fin = 1; end
      else if (blk == lim) wt++;
      tick;
    end
    process = 0; perm_done = 0; perm_ready = 1; msg_valid = 0;
    chk(ngot == nexp, "R4", {tag, " lane count"}, 64'(ngot), 64'(nexp));
    chk(!gap_bad, "R5", {tag, " no lane while block full / ready rule R3"}, 64'(gap_bad), 0);
    for (int i = 0; i < nexp && i < ngot; i++) begin
      string rq;
      if (md == 2 && i < lim) rq = "R2";
      else if (i < ppos) rq = "R3";
      else if (i == ppos) rq = part ? "R6" : "R7";
      else rq = "R8";
      chk(got[i] === exp[i], rq, $sformatf("%s lane %0d", tag, i), got[i], exp[i]);
    end
    msg_valid = 1; msg_data = wd(0); msg_strb = 8'hFF;
    tick; tick;
    chk(!perm_valid && !msg_ready, "R9", {tag, " back to idle"}, {perm_valid, msg_ready}, 0);
    msg_valid = 0;
  endtask

  task automatic t_reset;
    msg_valid = 1; msg_strb = 8'hFF;
    #1;
    chk(!perm_valid && !msg_ready && !err, "R1", "reset outputs quiet", {perm_valid, msg_ready, err}, 0);
    msg_valid = 0;
  endtask

  task automatic t_error;
    mode = 0; strength = 4;
    start = 1; tick; start = 0;
    msg_valid = 1; msg_data = wd(3); msg_strb = 8'hFF;
    #1;
    chk(perm_valid && perm_data == wd(3), "R3", "word forwarded before error", perm_data, wd(3));
    esc = 1; tick; esc = 0;
    chk(err && !perm_valid && !msg_ready, "R10", "error entered and quiet",
        {err, perm_valid, msg_ready}, 64'h4);
    start = 1; process = 1; tick; start = 0; process = 0; tick;
    chk(err && !perm_valid && !msg_ready, "R10", "error sticky", {err, perm_valid, msg_ready}, 64'h4);
    msg_valid = 0;
  endtask

  initial begin
    #400000;
    if (!ended) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    tick; tick;
    t_reset;
    rst_n = 1; tick;
    t_reset;
    absorb("sha3_partial3", 0, 2, 3, 1, 8'h07, 0);
    absorb("shake_one_block_proc_wait", 1, 4, 9, 0, 8'h00, 0);
    absorb("shake_12_stall", 1, 4, 12, 0, 8'h00, 1);
    absorb("sha3_pad_on_last", 0, 4, 8, 1, 8'h01, 0);
    absorb("cshake_prefix", 2, 0, 2, 0, 8'h00, 0);
    absorb("sha3_empty_partial", 0, 7, 0, 1, 8'h00, 0);
    absorb("cshake_partial7", 2, 3, 1, 1, 8'h7F, 1);
    for (int s = 1; s < 7; s += 2) absorb($sformatf("empty_s%0d", s), 1, s, 0, 0, 8'h00, 0);
    t_error;
    ended = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule